// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flow-Control Output

This block receives asynchronous serial characters on a single line. A programmable divider produces an oversampling tick at sixteen times the bit rate. A falling edge on the idle-high line starts a character. The start bit is then checked again at its middle, and a character begins only if the line is still low. Each data bit, the optional parity bit and the stop bits are sampled at the middle of their bit period. The bits are collected in a shift register, and the completed word moves into a receive buffer.

A pending-character flag and a one-cycle interrupt pulse report each buffer load. A flow-control output is high while a character waits, so the sender can be held off; a read strobe drops it again. Configuration selects the character length (7, 8 or 9 bits), parity on or off with its sense, one or two stop bits, inversion of the line polarity and reversal of the bit order into the buffer. Any mode code other than the three character-length codes holds the receiver in reset. Writing a valid code again restarts it cleanly after an error.

Top module: `async_rx`

## Requirements
- R1: One bit period lasts 16*(div_i+1) clock cycles. The divider and the oversample count restart on every detected start edge.
- R2: mode_i 100, 101 and 110 select 7, 8 and 9 data bits. Data arrives least significant bit first. data_o holds the word right-aligned, with unused upper bits zero.
- R3: A falling line edge starts a character only if the line is still low at the 8th oversample tick. A shorter low pulse is discarded: no load, no interrupt, and the receiver returns to idle.
- R4: With parity_en_i=1 one parity bit follows the data. The data bits plus the parity bit must hold an even count of ones when parity_odd_i=0, and an odd count when parity_odd_i=1. A mismatch sets parity_err_o with that character. With parity off, no parity bit is expected and parity_err_o is 0.
- R5: two_stop_i selects one or two stop bits. A low sample in any stop bit sets frame_err_o with that character.
- R6: After the last stop-bit sample, the word loads into the buffer, ri_o rises and irq_o pulses for one cycle. Both happen no later than 3 clocks after the middle of the last stop bit, and not before that stop bit.
- R7: rts_o is high while a character is pending. A one-cycle read strobe on rd_i clears ri_o and drops rts_o on the next cycle.
- R8: If a character completes while ri_o is still 1, overrun_o is set, the buffer keeps the older word, and irq_o does not pulse. A read clears overrun_o.
- R9: With invert_i=1 the rxd_i level is inverted ahead of all receive logic, so the line idles low.
- R10: With msb_first_i=1 the n received data bits are stored in reverse order: the first bit received lands at bit n-1 of data_o.
- R11: A mode_i value outside 100, 101 and 110 (for example 000) holds the receiver idle and clears ri_o, rts_o, overrun_o, both error flags and data_o. Writing a valid code again resumes reception from idle.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Mode code: 100/101/110 = 7/8/9 data bits; anything else = off |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop_i | input | 1 | 1 = two stop bits |
| invert_i | input | 1 | Invert the line polarity |
| msb_first_i | input | 1 | Reverse the bit order into the buffer |
| div_i | input | DIV_W | Baud divider value m; the tick comes every m+1 clocks |
| rxd_i | input | 1 | Serial input line |
| rd_i | input | 1 | Buffer read strobe |
| data_o | output | 9 | Receive buffer |
| ri_o | output | 1 | Character pending |
| rts_o | output | 1 | Flow control, high while a character is pending |
| irq_o | output | 1 | One-cycle pulse on each buffer load |
| parity_err_o | output | 1 | Parity error of the buffered character |
| frame_err_o | output | 1 | Stop-bit error of the buffered character |
| overrun_o | output | 1 | A character was lost while the buffer was full |

## Verification
The line passes through two synchronizer flops, so a buffer load becomes visible at most 3 clocks after the middle of the last stop bit. That moment is about 19 clocks into a 32-clock stop bit at div_i=1. Most checks therefore sample a full idle bit after the frame, well past the due cycle. One check samples 8 clocks into the stop bit, before the due cycle, to show that ri_o is not set early. A read strobe takes effect on the next edge, and the bench checks rts_o one cycle after releasing the strobe. Rejection of a short start pulse is checked a full two bit times after the glitch, once the qualification sample at the 8th tick has passed.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  localparam int MAX_BITS = 9;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rx_state_e;

  function automatic logic mode_is_uart(input logic [2:0] m);
    return (m == 3'b100) || (m == 3'b101) || (m == 3'b110);
  endfunction

  function automatic logic [3:0] mode_len(input logic [2:0] m);
    case (m)
      3'b100:  return 4'd7;
      3'b110:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/async_rx_baud.sv
module async_rx_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || !en_i)         cnt_q <= '0;
    else if (cnt_q == div_i)         cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && !clr_i && (cnt_q == div_i);

  // ticks are never adjacent unless the divider is 0
  a_r1_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || div_i != $past(div_i)));
endmodule

// File: rtl/async_rx_front.sv
module async_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic invert_i,
  output logic line_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
      prev_q <= line_o;
    end
  end

  assign line_o = sync_q[SYNC_STAGES-1] ^ invert_i;
  assign fall_o = prev_q && !line_o;
endmodule

// File: rtl/async_rx_fsm.sv
module async_rx_fsm
  import async_rx_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                tick_i,
  input  logic                line_i,
  input  logic                fall_i,
  input  logic [3:0]          n_bits_i,
  input  logic                parity_en_i,
  input  logic                parity_odd_i,
  input  logic                two_stop_i,
  output logic                clr_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] sr_o,
  output logic                perr_o,
  output logic                ferr_o
);
  localparam int OS_W = $clog2(OS_RATE);
  localparam logic [OS_W-1:0] MID  = OS_W'(OS_RATE / 2 - 1);
  localparam logic [OS_W-1:0] LAST = OS_W'(OS_RATE - 1);

  rx_state_e           state_q, state_d;
  logic [OS_W-1:0]     os_q, os_d;
  logic [3:0]          cnt_q, cnt_d;
  logic [MAX_BITS-1:0] sr_q, sr_d;
  logic                acc_q, acc_d, perr_q, perr_d, ferr_q, ferr_d;
  logic                sample;

  assign sample = tick_i && ((state_q == S_START) ? (os_q == MID) : (os_q == LAST));

  always_comb begin
    state_d = state_q; os_d = os_q; cnt_d = cnt_q; sr_d = sr_q;
    acc_d = acc_q; perr_d = perr_q; ferr_d = ferr_q;
    clr_o = 1'b0; done_o = 1'b0;
    if (tick_i) os_d = sample ? '0 : os_q + 1'b1;
    unique case (state_q)
      S_IDLE: if (fall_i) begin
        state_d = S_START; os_d = '0; clr_o = 1'b1;
      end
      S_START: if (sample) begin
        if (line_i) state_d = S_IDLE;  // start bit not confirmed
        else begin
          state_d = S_DATA; cnt_d = '0; sr_d = '0;
          acc_d = 1'b0; perr_d = 1'b0; ferr_d = 1'b0;
        end
      end
      S_DATA: if (sample) begin
        sr_d  = {line_i, sr_q[MAX_BITS-1:1]};
        acc_d = acc_q ^ line_i;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == n_bits_i - 1'b1) state_d = parity_en_i ? S_PAR : S_STOP1;
      end
      S_PAR: if (sample) begin
        perr_d  = acc_q ^ line_i ^ parity_odd_i;
        state_d = S_STOP1;
      end
      S_STOP1: if (sample) begin
        ferr_d = !line_i;
        if (two_stop_i) state_d = S_STOP2;
        else begin state_d = S_IDLE; done_o = 1'b1; end
      end
      S_STOP2: if (sample) begin
        ferr_d = ferr_q | !line_i;
        state_d = S_IDLE; done_o = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
    if (!en_i) begin
      state_d = S_IDLE; os_d = '0; done_o = 1'b0; clr_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; os_q <= '0; cnt_q <= '0; sr_q <= '0;
      acc_q <= 1'b0; perr_q <= 1'b0; ferr_q <= 1'b0;
    end else begin
      state_q <= state_d; os_q <= os_d; cnt_q <= cnt_d; sr_q <= sr_d;
      acc_q <= acc_d; perr_q <= perr_d; ferr_q <= ferr_d;
    end
  end

  assign sr_o   = sr_d;
  assign perr_o = perr_d;
  assign ferr_o = ferr_d;

  a_r3_start_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q != S_IDLE) |-> $past(!line_i));
  a_r6_done_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tick_i && en_i));
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic             parity_en_i,
  input  logic             parity_odd_i,
  input  logic             two_stop_i,
  input  logic             invert_i,
  input  logic             msb_first_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rxd_i,
  input  logic             rd_i,
  output logic [8:0]       data_o,
  output logic             ri_o,
  output logic             rts_o,
  output logic             irq_o,
  output logic             parity_err_o,
  output logic             frame_err_o,
  output logic             overrun_o
);
  localparam int DATA_W = MAX_BITS;

  logic              uart_on, tick, clr, line, fall, done, perr, ferr, load;
  logic [3:0]        n_bits;
  logic [DATA_W-1:0] sr, aligned, rev_full, word;
  logic [DATA_W-1:0] buf_q;
  logic              ri_q, ovr_q, perr_q, ferr_q, irq_q;

  assign uart_on = mode_is_uart(mode_i);
  assign n_bits  = mode_len(mode_i);

  async_rx_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk_i, .rst_ni, .rxd_i, .invert_i, .line_o(line), .fall_o(fall));

  async_rx_baud #(.DIV_W(DIV_W)) i_baud (
    .clk_i, .rst_ni, .en_i(uart_on), .clr_i(clr), .div_i, .tick_o(tick));

  async_rx_fsm #(.OS_RATE(OS_RATE)) i_fsm (
    .clk_i, .rst_ni, .en_i(uart_on), .tick_i(tick), .line_i(line), .fall_i(fall),
    .n_bits_i(n_bits), .parity_en_i, .parity_odd_i, .two_stop_i,
    .clr_o(clr), .done_o(done), .sr_o(sr), .perr_o(perr), .ferr_o(ferr));

  // shift register is left-aligned; full reversal already right-aligns reversed data
  assign aligned = sr >> (4'(DATA_W) - n_bits);
  for (genvar k = 0; k < DATA_W; k++) begin : g_rev
    assign rev_full[k] = sr[DATA_W-1-k];
  end
  assign word = msb_first_i ? rev_full : aligned;
  assign load = done && (!ri_q || rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0; ri_q <= 1'b0; ovr_q <= 1'b0;
      perr_q <= 1'b0; ferr_q <= 1'b0; irq_q <= 1'b0;
    end else if (!uart_on) begin
      buf_q <= '0; ri_q <= 1'b0; ovr_q <= 1'b0;
      perr_q <= 1'b0; ferr_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= load;
      if (load) begin
        buf_q <= word; ri_q <= 1'b1; perr_q <= perr; ferr_q <= ferr;
      end else if (rd_i) begin
        ri_q <= 1'b0;
      end
      if (done && ri_q && !rd_i) ovr_q <= 1'b1;
      else if (rd_i)             ovr_q <= 1'b0;
    end
  end

  assign data_o       = buf_q;
  assign ri_o         = ri_q;
  assign rts_o        = ri_q;
  assign irq_o        = irq_q;
  assign parity_err_o = perr_q;
  assign frame_err_o  = ferr_q;
  assign overrun_o    = ovr_q;

  a_r6_load_sets_ri: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_on && done) |=> ri_o);
  a_r8_overrun_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_on && done && ri_o && !rd_i) |=> ($stable(data_o) && overrun_o && !irq_o));
  a_r7_rts_drops_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_on && rd_i && !done) |=> !rts_o);
  a_r11_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uart_on |=> (!ri_o && !overrun_o && data_o == '0));
endmodule

// File: tb/test_async_rx.sv
module test_async_rx;
  localparam int DIV_W = 12;

  logic             clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0]       mode_i = 3'b101;
  logic             parity_en_i = 1'b0, parity_odd_i = 1'b0, two_stop_i = 1'b0;
  logic             invert_i = 1'b0, msb_first_i = 1'b0;
  logic [DIV_W-1:0] div_i = 12'd1;
  logic             rxd_i = 1'b1, rd_i = 1'b0;
  logic [8:0]       data_o;
  logic             ri_o, rts_o, irq_o, parity_err_o, frame_err_o, overrun_o;

  int n_chk = 0, n_fail = 0, irq_cnt = 0, bclk = 32;
  logic inv_b = 1'b0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) if (irq_o) irq_cnt <= irq_cnt + 1;

  async_rx #(.DIV_W(DIV_W)) i_async_rx (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic drive(input logic lvl, input int n);
    rxd_i = lvl ^ inv_b;
    wait_clk(n);
  endtask

  function automatic logic par(input logic [8:0] d, input int nb, input logic odd);
    logic p = odd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  task automatic send(input logic [8:0] d, input int nb, input logic pen, input logic pbit,
                      input int nstop, input logic s1);
    drive(1'b0, bclk);
    for (int i = 0; i < nb; i++) drive(d[i], bclk);
    if (pen) drive(pbit, bclk);
    drive(s1, bclk);
    if (nstop == 2) drive(1'b1, bclk);
    drive(1'b1, bclk);
  endtask

  task automatic rd_pulse();
    rd_i = 1'b1; wait_clk(1); rd_i = 1'b0; wait_clk(1);
  endtask

  task automatic t_reset();
    chk("R12 ri", ri_o, 0); chk("R12 rts", rts_o, 0); chk("R12 data", data_o, 0);
    chk("R12 ovr", overrun_o, 0); chk("R12 ferr", frame_err_o, 0);
    chk("R12 perr", parity_err_o, 0); chk("R12 irq", irq_o, 0);
  endtask

  task automatic t_basic();
    int i0 = irq_cnt;
    send(9'h0A5, 8, 1'b0, 1'b0, 1, 1'b1);
    chk("R2 data 8b", data_o, 'hA5); chk("R6 ri", ri_o, 1);
    chk("R7 rts high", rts_o, 1); chk("R6 irq once", irq_cnt - i0, 1);
    chk("R4 perr off", parity_err_o, 0); chk("R5 ferr", frame_err_o, 0);
    rd_pulse();
    chk("R7 ri cleared", ri_o, 0); chk("R7 rts low", rts_o, 0);
  endtask

  task automatic t_timing();
    logic [7:0] d = 8'h5A;
    drive(1'b0, bclk);
    for (int i = 0; i < 8; i++) drive(d[i], bclk);
    drive(1'b1, 8);
    chk("R6 not early", ri_o, 0);
    wait_clk(bclk - 8 + bclk);
    chk("R6 due", ri_o, 1); chk("R6 data", data_o, 'h5A);
    rd_pulse();
  endtask

  task automatic t_len7_par();
    mode_i = 3'b100; parity_en_i = 1'b1; parity_odd_i = 1'b0; wait_clk(4);
    send(9'h05A, 7, 1'b1, par(9'h05A, 7, 1'b0), 1, 1'b1);
    chk("R2 data 7b", data_o, 'h5A); chk("R4 even ok", parity_err_o, 0);
    rd_pulse();
    send(9'h07F, 7, 1'b1, ~par(9'h07F, 7, 1'b0), 1, 1'b1);
    chk("R2 upper zero", data_o, 'h7F); chk("R4 even bad", parity_err_o, 1);
    rd_pulse();
    parity_en_i = 1'b0;
  endtask

  task automatic t_len9();
    mode_i = 3'b110; parity_en_i = 1'b1; parity_odd_i = 1'b1; two_stop_i = 1'b1; wait_clk(4);
    send(9'h1C3, 9, 1'b1, par(9'h1C3, 9, 1'b1), 2, 1'b1);
    chk("R2 data 9b", data_o, 'h1C3); chk("R4 odd ok", parity_err_o, 0);
    chk("R5 two stop ok", frame_err_o, 0);
    rd_pulse();
    send(9'h0F0, 9, 1'b1, par(9'h0F0, 9, 1'b1), 2, 1'b0);
    chk("R5 two stop first low", frame_err_o, 1);
    rd_pulse();
    parity_en_i = 1'b0; parity_odd_i = 1'b0; two_stop_i = 1'b0; mode_i = 3'b101; wait_clk(4);
  endtask

  task automatic t_frame();
    send(9'h033, 8, 1'b0, 1'b0, 1, 1'b0);
    chk("R5 ferr", frame_err_o, 1); chk("R5 data", data_o, 'h33);
    rd_pulse();
  endtask

  task automatic t_false_start();
    int i0 = irq_cnt;
    drive(1'b0, 8); drive(1'b1, 2 * bclk);
    chk("R3 glitch ignored ri", ri_o, 0); chk("R3 glitch no irq", irq_cnt - i0, 0);
    send(9'h03C, 8, 1'b0, 1'b0, 1, 1'b1);
    chk("R3 recovers", data_o, 'h3C);
    rd_pulse();
  endtask

  task automatic t_invert();
    invert_i = 1'b1; inv_b = 1'b1; rxd_i = 1'b0; wait_clk(3 * bclk);
    send(9'h0C3, 8, 1'b0, 1'b0, 1, 1'b1);
    chk("R9 inverted data", data_o, 'hC3); chk("R9 ferr", frame_err_o, 0);
    rd_pulse();
    invert_i = 1'b0; inv_b = 1'b0; rxd_i = 1'b1; wait_clk(3 * bclk);
    chk("R9 restore no char", ri_o, 0);
  endtask

  task automatic t_reverse();
    msb_first_i = 1'b1; wait_clk(4);
    send(9'h001, 8, 1'b0, 1'b0, 1, 1'b1);
    chk("R10 reversed 8b", data_o, 'h80);
    rd_pulse();
    mode_i = 3'b100; wait_clk(4);
    send(9'h003, 7, 1'b0, 1'b0, 1, 1'b1);
    chk("R10 reversed 7b", data_o, 'h60);
    rd_pulse();
    msb_first_i = 1'b0; mode_i = 3'b101; wait_clk(4);
  endtask

  task automatic t_overrun();
    int i0 = irq_cnt;
    send(9'h011, 8, 1'b0, 1'b0, 1, 1'b1);
    send(9'h022, 8, 1'b0, 1'b0, 1, 1'b1);
    chk("R8 keeps old", data_o, 'h11); chk("R8 ovr set", overrun_o, 1);
    chk("R8 ri stays", ri_o, 1); chk("R8 one irq", irq_cnt - i0, 1);
    rd_pulse();
    chk("R8 ovr cleared", overrun_o, 0); chk("R8 ri cleared", ri_o, 0);
  endtask

  task automatic t_mode_off();
    send(9'h044, 8, 1'b0, 1'b0, 1, 1'b1);
    mode_i = 3'b000; wait_clk(4);
    chk("R11 ri", ri_o, 0); chk("R11 rts", rts_o, 0); chk("R11 data", data_o, 0);
    mode_i = 3'b101; wait_clk(4);
    send(9'h055, 8, 1'b0, 1'b0, 1, 1'b1);
    chk("R11 resumes", data_o, 'h55); chk("R11 ri", ri_o, 1);
    rd_pulse();
  endtask

  task automatic t_div();
    div_i = 12'd3; bclk = 64; wait_clk(4);
    send(9'h096, 8, 1'b0, 1'b0, 1, 1'b1);
    chk("R1 div3 data", data_o, 'h96); chk("R1 div3 ferr", frame_err_o, 0);
    rd_pulse();
    div_i = 12'd1; bclk = 32; wait_clk(4);
  endtask

  initial begin
    wait_clk(3); rst_ni = 1'b1; wait_clk(2);
    t_reset();
    t_basic();
    t_timing();
    t_len7_par();
    t_len9();
    t_frame();
    t_false_start();
    t_invert();
    t_reverse();
    t_overrun();
    t_mode_off();
    t_div();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule